// File: doc/BRIEF.md
# Palette Colour Lookup with Host Register Port

This block is the host-facing register front end and colour lookup table of a display palette converter. A host reaches it through four byte-wide I/O ports. The port decode turns the I/O address into a select for the block and a two-bit register number, which is taken straight from the two lowest address bits. Through these ports the host programs a 256-entry table, with one red, green and blue component per entry. It also sets a pixel mask and positions separate read and write pointers into the table.

On the display side, a pixel index, ANDed with the mask, selects one table entry. That entry's three components appear on the colour output one clock later. In gamma mode the block instead takes a direct-colour pixel. Each of its red, green and blue bytes is used as its own index into the matching component column of the table, so the table becomes a per-channel transfer curve. A width input chooses between 6-bit and 8-bit components.

Top module: `dac_palette`

## Requirements
- R1: Only the four I/O addresses 3C6h, 3C7h, 3C8h and 3C9h select the block. Reads of any other address return 0, and writes to any other address (for example 3C5h or 3CAh) change neither the registers nor the table.
- R2: The register number equals address bits [1:0]. Number 0 (3C8h) is the write pointer, 3 (3C7h) the read pointer, 2 (3C6h) the pixel mask, and 1 (3C9h) the colour data port. Reading number 0 returns the write pointer, number 3 the read pointer, and number 2 the mask.
- R3: Successive writes to the data port store red, then green, then blue at the write pointer. After the blue write, the write pointer increments and wraps from 255 to 0.
- R4: Successive reads of the data port return red, then green, then blue of the entry at the read pointer. After the blue read, the read pointer increments.
- R5: Writing either pointer restarts the component sequence at red.
- R6: With the width input low (6-bit mode), a data write stores only bits [5:0] and a data read returns the stored bits [5:0] with bits [7:6] zero. Each output component is the stored bits [5:0] shifted left by two, so bits [1:0] are zero.
- R7: With the width input high (8-bit mode), components are stored, read and output as full bytes.
- R8: With gamma low, the output one clock after a pixel index is presented is the entry at (index AND mask). The output is {red[23:16], green[15:8], blue[7:0]}.
- R9: With gamma high, output red is the red component of entry pixRgb[23:16], output green is the green component of entry pixRgb[15:8], and output blue is the blue component of entry pixRgb[7:0]. The result appears one clock later and the mask is not applied.
- R10: After reset, the mask is FFh, both pointers are 0, the component sequence is at red, and the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | Host I/O address |
| ioWr | input | 1 | One-cycle host write strobe |
| ioRd | input | 1 | One-cycle host read strobe |
| ioWData | input | 8 | Host write data |
| ioRData | output | 8 | Host read data, combinational from the address |
| wide | input | 1 | 1 selects 8-bit components, 0 selects 6-bit |
| gamma | input | 1 | 1 selects the per-channel gamma lookup |
| pixIdx | input | 8 | Palette pixel index |
| pixRgb | input | 24 | Direct-colour pixel for gamma mode |
| rgbOut | output | 24 | Looked-up colour, registered |

## Verification
The whole table is first filled with a non-repeating byte pattern through the data port, and the run crosses the 255-to-0 pointer wrap; this separates correct component ordering and auto-increment from a swapped or stuck counter. Pixel indices sweep all entries with several mask values, which exposes a missing or misplaced mask. Gamma mode is driven with distinct red, green and blue bytes, so a channel that uses the wrong index or the wrong column shows up. Narrow-mode writes use bytes with their top bits set, and out-of-window addresses 3C5h and 3CAh are written between readbacks.

// File: rtl/dac_pkg.sv
package dac_pkg;
  parameter int IDX_W  = 8;
  parameter int COMP_W = 8;
  parameter int NCH    = 3;
  localparam int CNT_W = 2;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [CNT_W-1:0]  wrComp;
    logic [COMP_W-1:0] wrData;
    logic [IDX_W-1:0]  rdIdx;
    logic [CNT_W-1:0]  rdComp;
    logic [IDX_W-1:0]  pixMask;
  } dacStrobes_t;
endpackage

// File: rtl/dac_ctrl.sv
module dac_ctrl
  import dac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_LO = 16'h03C6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [COMP_W-1:0] ioWData,
  input  logic              wide,
  input  logic [COMP_W-1:0] rdVal,
  output logic [COMP_W-1:0] ioRData,
  output dacStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] PORT_HI = PORT_LO + ADDR_W'(3);
  localparam logic [CNT_W-1:0]  LAST_COMP = CNT_W'(NCH - 1);
  localparam int NARROW_W = COMP_W - 2;

  localparam logic [1:0] RS_WIDX = 2'd0;
  localparam logic [1:0] RS_DATA = 2'd1;
  localparam logic [1:0] RS_MASK = 2'd2;
  localparam logic [1:0] RS_RIDX = 2'd3;

  logic              cs;
  logic [1:0]        rs;
  logic              wrAcc, rdAcc;
  logic [IDX_W-1:0]  wrIdx, rdIdx, mask;
  logic [CNT_W-1:0]  cnt;
  logic [COMP_W-1:0] narrowIn, narrowOut;

  assign cs    = (ioAddr >= PORT_LO) && (ioAddr <= PORT_HI);
  assign rs    = ioAddr[1:0];
  assign wrAcc = cs && ioWr;
  assign rdAcc = cs && ioRd && !ioWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      mask  <= '1;
      cnt   <= '0;
    end else if (wrAcc) begin
      unique case (rs)
        RS_WIDX: begin wrIdx <= ioWData[IDX_W-1:0]; cnt <= '0; end
        RS_RIDX: begin rdIdx <= ioWData[IDX_W-1:0]; cnt <= '0; end
        RS_MASK: mask <= ioWData[IDX_W-1:0];
        default: begin
          if (cnt == LAST_COMP) begin
            cnt   <= '0;
            wrIdx <= wrIdx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end else if (rdAcc && rs == RS_DATA) begin
      if (cnt == LAST_COMP) begin
        cnt   <= '0;
        rdIdx <= rdIdx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign narrowIn  = {2'b00, ioWData[NARROW_W-1:0]};
  assign narrowOut = {2'b00, rdVal[NARROW_W-1:0]};

  always_comb begin
    strobes.wrEn    = wrAcc && (rs == RS_DATA);
    strobes.wrIdx   = wrIdx;
    strobes.wrComp  = cnt;
    strobes.wrData  = wide ? ioWData : narrowIn;
    strobes.rdIdx   = rdIdx;
    strobes.rdComp  = cnt;
    strobes.pixMask = mask;
  end

  always_comb begin
    ioRData = '0;
    if (cs) begin
      unique case (rs)
        RS_WIDX: ioRData = COMP_W'(wrIdx);
        RS_RIDX: ioRData = COMP_W'(rdIdx);
        RS_MASK: ioRData = COMP_W'(mask);
        default: ioRData = wide ? rdVal : narrowOut;
      endcase
    end
  end

  // R1: accesses outside the window leave all state untouched
  a_r1_outside_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cs |=> ($stable(wrIdx) && $stable(rdIdx) && $stable(mask) && $stable(cnt)));

  // R3: third data write advances the write pointer by one
  a_r3_wr_advance: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && rs == RS_DATA && cnt == LAST_COMP) |=> (wrIdx == $past(wrIdx) + 1'b1) && (cnt == '0));

  // R4: third data read advances the read pointer by one
  a_r4_rd_advance: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && rs == RS_DATA && cnt == LAST_COMP) |=> (rdIdx == $past(rdIdx) + 1'b1) && (cnt == '0));

  // R5: a pointer load restarts the component sequence
  a_r5_ptr_restart: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && (rs == RS_WIDX || rs == RS_RIDX)) |=> (cnt == '0));

  // R3: the component counter never leaves red..blue
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST_COMP);
endmodule

// File: rtl/dac_data.sv
module dac_data
  import dac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  dacStrobes_t           strobes,
  input  logic                  wide,
  input  logic                  gamma,
  input  logic [IDX_W-1:0]      pixIdx,
  input  logic [NCH*IDX_W-1:0]  pixRgb,
  output logic [COMP_W-1:0]     rdVal,
  output logic [NCH*COMP_W-1:0] rgbOut
);
  localparam int DEPTH    = 1 << IDX_W;
  localparam int NARROW_W = COMP_W - 2;

  logic [NCH*COMP_W-1:0] rdBus;
  logic [IDX_W-1:0]      palAddr;

  assign palAddr = pixIdx & strobes.pixMask;

  for (genvar ch = 0; ch < NCH; ch++) begin : gen_ch
    localparam int LO  = (NCH - 1 - ch) * COMP_W;
    localparam int ILO = (NCH - 1 - ch) * IDX_W;

    logic [COMP_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  lookAddr;
    logic [COMP_W-1:0] raw, shaped, q;

    always_ff @(posedge clk) begin
      if (strobes.wrEn && strobes.wrComp == CNT_W'(ch))
        mem[strobes.wrIdx] <= strobes.wrData;
    end

    assign lookAddr = gamma ? pixRgb[ILO +: IDX_W] : palAddr;
    assign raw      = mem[lookAddr];
    assign shaped   = wide ? raw : {raw[NARROW_W-1:0], 2'b00};

    always_ff @(posedge clk) begin
      if (!rstN) q <= '0;
      else       q <= shaped;
    end

    assign rgbOut[LO +: COMP_W] = q;
    assign rdBus[LO +: COMP_W]  = mem[strobes.rdIdx];

    // R6: narrow components leave the two low output bits clear
    a_r6_narrow_low: assert property (@(posedge clk) disable iff (!rstN)
      !$past(wide) |-> (q[1:0] == 2'b00));
  end

  always_comb begin
    rdVal = '0;
    for (int ch = 0; ch < NCH; ch++)
      if (strobes.rdComp == CNT_W'(ch))
        rdVal = rdBus[(NCH - 1 - ch) * COMP_W +: COMP_W];
  end
endmodule

// File: rtl/dac_palette.sv
module dac_palette
  import dac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_LO = 16'h03C6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     ioAddr,
  input  logic                  ioWr,
  input  logic                  ioRd,
  input  logic [COMP_W-1:0]     ioWData,
  output logic [COMP_W-1:0]     ioRData,
  input  logic                  wide,
  input  logic                  gamma,
  input  logic [IDX_W-1:0]      pixIdx,
  input  logic [NCH*IDX_W-1:0]  pixRgb,
  output logic [NCH*COMP_W-1:0] rgbOut
);
  dacStrobes_t       strobes;
  logic [COMP_W-1:0] rdVal;

  dac_ctrl #(.ADDR_W(ADDR_W), .PORT_LO(PORT_LO)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWData(ioWData), .wide(wide), .rdVal(rdVal), .ioRData(ioRData),
    .strobes(strobes)
  );

  dac_data u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wide(wide), .gamma(gamma),
    .pixIdx(pixIdx), .pixRgb(pixRgb), .rdVal(rdVal), .rgbOut(rgbOut)
  );
endmodule

// File: tb/dac_palette_tb.sv
module dac_palette_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0]  ioWData = '0;
  logic [7:0]  ioRData;
  logic        wide = 1'b1, gamma = 1'b0;
  logic [7:0]  pixIdx = '0;
  logic [23:0] pixRgb = '0;
  logic [23:0] rgbOut;

  always #2 clk = ~clk;

  dac_palette u_dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWData(ioWData), .ioRData(ioRData), .wide(wide), .gamma(gamma),
    .pixIdx(pixIdx), .pixRgb(pixRgb), .rgbOut(rgbOut)
  );

  int errs = 0, checks = 0;
  bit cmpEn = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // reference model
  logic [7:0]  mPal [256][3];
  int          mWr, mRd, mCnt;
  logic [7:0]  mMask;
  logic [23:0] expOut;

  function automatic bit inWin(logic [15:0] a);
    return a >= 16'h03C6 && a <= 16'h03C9;
  endfunction

  function automatic logic [7:0] shapeOut(logic [7:0] v);
    return wide ? v : {v[5:0], 2'b00};
  endfunction

  function automatic logic [7:0] modelRead(logic [15:0] a);
    logic [7:0] p;
    if (!inWin(a)) return 8'h00;
    case (a)
      16'h03C6: return mMask;
      16'h03C7: return 8'(mRd);
      16'h03C8: return 8'(mWr);
      default: begin
        p = mPal[mRd][mCnt];
        return wide ? p : {2'b00, p[5:0]};
      end
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      expOut = '0; mWr = 0; mRd = 0; mCnt = 0; mMask = 8'hFF;
    end else begin
      for (int ch = 0; ch < 3; ch++) begin
        int idx;
        idx = gamma ? int'(pixRgb[(2-ch)*8 +: 8]) : int'(pixIdx & mMask);
        expOut[(2-ch)*8 +: 8] = shapeOut(mPal[idx][ch]);
      end
      if (ioWr && inWin(ioAddr)) begin
        case (ioAddr)
          16'h03C8: begin mWr = int'(ioWData); mCnt = 0; end
          16'h03C7: begin mRd = int'(ioWData); mCnt = 0; end
          16'h03C6: mMask = ioWData;
          default: begin
            mPal[mWr][mCnt] = wide ? ioWData : {2'b00, ioWData[5:0]};
            if (mCnt == 2) begin mCnt = 0; mWr = (mWr + 1) % 256; end
            else mCnt++;
          end
        endcase
      end else if (ioRd && ioAddr == 16'h03C9) begin
        if (mCnt == 2) begin mCnt = 0; mRd = (mRd + 1) % 256; end
        else mCnt++;
      end
    end
  end

  always @(negedge clk)
    if (cmpEn && rstN) chk(gamma ? "R9 gamma output" : "R8 palette output", rgbOut, expOut);

  task automatic wrPort(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWr = 1'b1; ioRd = 1'b0; ioWData = d;
  endtask

  task automatic rdPort(logic [15:0] a, string tag);
    @(negedge clk);
    ioAddr = a; ioWr = 1'b0; ioRd = 1'b1;
    #1 chk(tag, ioRData, modelRead(a));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ioWr = 1'b0; ioRd = 1'b0;
    end
  endtask

  task automatic pix(logic [7:0] v);
    @(negedge clk);
    ioWr = 1'b0; ioRd = 1'b0; pixIdx = v;
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog run did not complete");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 output in reset", rgbOut, 24'h0);
    rstN = 1'b1;
    // R10 reset state through the port
    rdPort(16'h03C6, "R10 mask reset");
    #1 chk("R10 mask is FF", ioRData, 8'hFF);
    rdPort(16'h03C7, "R10 read ptr reset");
    rdPort(16'h03C8, "R10 write ptr reset");

    // R3, R7: fill whole table, crossing the pointer wrap
    wrPort(16'h03C8, 8'h00);
    for (int i = 0; i < 768; i++) wrPort(16'h03C9, 8'((i * 37 + 11) & 255));
    rdPort(16'h03C8, "R3 write ptr wrapped");
    #1 chk("R3 wrap to zero", ioRData, 8'h00);
    idle(1);
    cmpEn = 1;

    // R8: sweep indices with full and partial masks
    for (int i = 0; i < 256; i += 7) pix(8'(i));
    for (int b = 0; b < 8; b++) pix(8'(1 << b));
    wrPort(16'h03C6, 8'h0F);
    rdPort(16'h03C6, "R2 mask readback");
    for (int i = 0; i < 256; i += 13) pix(8'(i));
    wrPort(16'h03C6, 8'hA5);
    for (int i = 0; i < 64; i++) pix(8'(i * 5));

    // R4: read sequence across an entry boundary
    wrPort(16'h03C7, 8'h05);
    rdPort(16'h03C9, "R4 red of 5");
    #1 chk("R4 red literal", ioRData, 8'((15 * 37 + 11) & 255));
    for (int i = 0; i < 5; i++) rdPort(16'h03C9, "R4 data read");
    rdPort(16'h03C7, "R4 read ptr advanced");
    #1 chk("R4 read ptr is 7", ioRData, 8'h07);

    // R5: pointer reload restarts at red
    wrPort(16'h03C8, 8'd10);
    wrPort(16'h03C9, 8'h11);
    wrPort(16'h03C9, 8'h22);
    wrPort(16'h03C8, 8'd20);
    wrPort(16'h03C9, 8'h33);
    wrPort(16'h03C9, 8'h44);
    wrPort(16'h03C9, 8'h55);
    wrPort(16'h03C7, 8'd20);
    rdPort(16'h03C9, "R5 red after reload");
    #1 chk("R5 red literal", ioRData, 8'h33);
    rdPort(16'h03C9, "R5 green");
    rdPort(16'h03C9, "R5 blue");
    wrPort(16'h03C7, 8'd10);
    rdPort(16'h03C9, "R5 partial entry red");
    #1 chk("R5 partial red literal", ioRData, 8'h11);

    // R1: out-of-window writes and reads
    wrPort(16'h03C5, 8'h77);
    wrPort(16'h03CA, 8'h66);
    rdPort(16'h03C5, "R1 read 3C5");
    #1 chk("R1 3C5 reads zero", ioRData, 8'h00);
    rdPort(16'h03CA, "R1 read 3CA");
    rdPort(16'h03C6, "R1 mask unchanged");
    #1 chk("R1 mask literal", ioRData, 8'hA5);
    rdPort(16'h03C8, "R1 write ptr unchanged");
    rdPort(16'h03C9, "R1 sequence unchanged");
    for (int i = 0; i < 16; i++) pix(8'(i + 20));

    // R6: narrow components
    wrPort(16'h03C6, 8'hFF);
    @(negedge clk); wide = 1'b0; ioWr = 1'b0; ioRd = 1'b0;
    wrPort(16'h03C8, 8'd30);
    wrPort(16'h03C9, 8'hFF);
    wrPort(16'h03C9, 8'hC3);
    wrPort(16'h03C9, 8'h81);
    wrPort(16'h03C7, 8'd30);
    rdPort(16'h03C9, "R6 narrow red");
    #1 chk("R6 narrow red literal", ioRData, 8'h3F);
    rdPort(16'h03C9, "R6 narrow green");
    rdPort(16'h03C9, "R6 narrow blue");
    #1 chk("R6 narrow blue literal", ioRData, 8'h01);
    pix(8'd30);
    pix(8'd31);
    #1 chk("R6 narrow output", rgbOut, 24'hFC_0C_04);
    for (int i = 0; i < 40; i++) pix(8'(i * 6));

    // R9: gamma lookup with distinct channels and a mask that must be ignored
    wrPort(16'h03C6, 8'h03);
    @(negedge clk); gamma = 1'b1; ioWr = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      pixRgb = {8'(i * 3), 8'(255 - i * 4), 8'(i * 11 + 30)};
    end
    @(negedge clk); wide = 1'b1; pixRgb = 24'h1E_0A_14;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      pixRgb = {8'(i * 7), 8'(i * 2 + 100), 8'(200 - i)};
    end
    idle(2);
    cmpEn = 0;
    idle(1);
    finish();
  end
endmodule